// File: doc/BRIEF.md
# Deep Standby Wake-Up Controller

This block decides when a chip leaves its deepest low-power state. It runs from an always-on low-speed clock. While the chip is awake it keeps the oscillator and the clock output pin enabled. A one-cycle standby request stops both and arms the wake logic. Three kinds of source can wake the chip: the non-maskable interrupt pin, any wake pin selected by a mask, and a real-time-clock alarm. Each pin carries its own polarity setting, which picks a rising or a falling wake edge.

A pin edge is judged against the level the pin had when standby began. When a source fires, the oscillator is switched back on and a programmable settling count runs out. After that the block issues a power-on reset pulse rather than letting execution resume. The external reset pin is a second way out. Pulling it low during standby brings the oscillator and the clock output straight back and holds a reset request. That request is released only once the settling count has finished and the pin is high again.

When standby begins, any selected pin found at the level it is meant to move to raises a sticky warning flag. Standby is still entered. A status register keeps one bit for every source that fired, and software clears it by writing ones.

Top module: `dsw_wake_ctrl`

## Requirements
- R1: After `rst_n` is released the block is awake: `in_stby`=0, `osc_en`=1, `clko_en`=1, `por_req`=0, `wake_status`=0 and `entry_viol`=0. Whenever `in_stby` is 0, `osc_en` and `clko_en` are both 1.
- R2: A `stby_req` pulse while awake sets `in_stby`=1 and clears `osc_en` and `clko_en` on the next clock edge.
- R3: At standby entry, `entry_viol` is set if the NMI pin or any selected wake pin already sits at its wake level (high when its rise bit is 1, low when it is 0). Standby is entered anyway, and the flag then stays set until `rst_n`.
- R4: In standby a wake event is one of two things. The first is a synchronised NMI pin or selected wake pin that has reached its wake level and differs from the level captured at entry. The second is a synchronised alarm that is high. Pins whose `pin_sel` bit is 0 have no effect.
- R5: On a wake event, `osc_en` rises while `clko_en` and `por_req` stay 0 for `settle_cycles`+1 cycles. Then `por_req` is 1 for exactly one cycle, after which the block is awake again.
- R6: `wake_status` bit 0 records NMI, bit 1 records the alarm and bit 2+i records wake pin i. Every source firing in the same cycle sets its bit. A bit never clears except by an explicit clear.
- R7: A cycle with `stat_clr_we`=1 clears each `wake_status` bit whose `stat_clr_data` bit is 1 and keeps the others.
- R8: `rst_pin_n` low during standby or settling gives `osc_en`=1, `clko_en`=1 and `por_req`=1 within three clock edges. `wake_status` is not changed.
- R9: On the reset-pin path `por_req` stays 1 until the settling count has ended and the synchronised `rst_pin_n` is high. A pin released early is held off until the count is done.
- R10: `rst_pin_n` low while awake has no effect: `por_req` stays 0 and `in_stby` stays 0.
- R11: The pin inputs, the alarm and `rst_pin_n` each pass through a two-flop synchroniser before any decision is made on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed clock |
| rst_n | input | 1 | Asynchronous always-on domain reset, active low |
| stby_req | input | 1 | One-cycle request to enter standby |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| nmi_rise | input | 1 | 1: NMI wakes on a rising edge, 0: on a falling edge |
| wake_pin | input | NPINS | Wake pins |
| pin_sel | input | NPINS | 1 enables the matching wake pin |
| pin_rise | input | NPINS | Per-pin polarity, 1 rising, 0 falling |
| alarm_in | input | 1 | Real-time-clock alarm, active high |
| rst_pin_n | input | 1 | External reset pin, active low |
| settle_cycles | input | CW | Oscillator settling count in clock cycles |
| stat_clr_we | input | 1 | Write strobe for clearing status bits |
| stat_clr_data | input | NPINS+2 | Ones mark the status bits to clear |
| osc_en | output | 1 | Oscillator enable |
| clko_en | output | 1 | Clock output pin enable |
| por_req | output | 1 | Power-on reset request |
| in_stby | output | 1 | 1 from standby entry until the block is awake again |
| wake_status | output | NPINS+2 | Record of the sources that fired |
| entry_viol | output | 1 | Sticky flag for a wrong pin level at entry |

## Verification
Each state of the controller drives its own mix of `osc_en`, `clko_en` and `por_req`. A wrong state therefore shows at the ports on the very next cycle. A captured entry level that is wrong, or a selection mask that is wrong, shows differently. Either a wake that should happen does not come, and `osc_en` stays low, or a wake arrives while a pin is held steady. Both show within three cycles of the pin change. A settling counter that is off by any amount moves the `por_req` pulse. The bench measures the distance from the rise of `osc_en` to that pulse and compares it with `settle_cycles`+1.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE   = 3'd0,
    ST_ASLEEP  = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_PORPULS = 3'd3,
    ST_PINHOLD = 3'd4
  } dsw_state_e;

  // a pin already at its wake level when standby begins
  function automatic logic lvl_is_wrong(input logic lvl, input logic rise);
    return lvl == rise;
  endfunction

  // wake condition: reached target level and moved away from entry level
  function automatic logic lvl_reached(input logic cur, input logic at_entry,
                                       input logic rise);
    return (cur == rise) && (cur != at_entry);
  endfunction

  // write-one-to-clear with set priority
  function automatic logic stat_next(input logic cur, input logic clr,
                                     input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/dsw_edge.sv
module dsw_edge
  import dsw_pkg::*;
#(
  parameter int NP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [NP-1:0] lvl,
  input  logic [NP-1:0] sel,
  input  logic [NP-1:0] rise,
  output logic [NP-1:0] hit,
  output logic          viol_now
);
  logic [NP-1:0] ent_lvl;
  logic [NP-1:0] ent_sel;
  logic [NP-1:0] ent_rise;
  logic [NP-1:0] wrong_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_lvl  <= '0;
      ent_sel  <= '0;
      ent_rise <= '0;
    end else if (capture) begin
      ent_lvl  <= lvl;
      ent_sel  <= sel;
      ent_rise <= rise;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_bit
    assign wrong_vec[i] = sel[i] & lvl_is_wrong(lvl[i], rise[i]);
    assign hit[i]       = ent_sel[i] & lvl_reached(lvl[i], ent_lvl[i], ent_rise[i]);
  end

  assign viol_now = |wrong_vec;
endmodule

// File: rtl/dsw_settle_cnt.sv
module dsw_settle_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (run && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = (remain == '0);
endmodule

// File: rtl/dsw_wake_ctrl.sv
module dsw_wake_ctrl
  import dsw_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int CW    = 16,
  parameter int SW    = NPINS + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby_req,
  input  logic             nmi_pin,
  input  logic             nmi_rise,
  input  logic [NPINS-1:0] wake_pin,
  input  logic [NPINS-1:0] pin_sel,
  input  logic [NPINS-1:0] pin_rise,
  input  logic             alarm_in,
  input  logic             rst_pin_n,
  input  logic [CW-1:0]    settle_cycles,
  input  logic             stat_clr_we,
  input  logic [SW-1:0]    stat_clr_data,
  output logic             osc_en,
  output logic             clko_en,
  output logic             por_req,
  output logic             in_stby,
  output logic [SW-1:0]    wake_status,
  output logic             entry_viol
);
  localparam int NP = NPINS + 1;   // NMI plus wake pins
  localparam int NS = NPINS + 2;   // synchronised data inputs

  dsw_state_e state, state_nx;

  // synchronised inputs
  logic [NS-1:0] raw_in, syn_in;
  logic          rst_s;
  logic          nmi_s, alarm_s;
  logic [NPINS-1:0] pin_s;

  assign raw_in = {alarm_in, wake_pin, nmi_pin};

  dsw_sync #(.W(NS), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  dsw_sync #(.W(1), .RST_VAL(1'b1)) u_sync_rst (
    .clk(clk), .rst_n(rst_n), .d(rst_pin_n), .q(rst_s)
  );

  assign nmi_s   = syn_in[0];
  assign pin_s   = syn_in[NS-2:1];
  assign alarm_s = syn_in[NS-1];

  // named internal events
  logic          enter_now;
  logic          stby_wait;
  logic          wake_any;
  logic          rst_drop;
  logic          cnt_done;
  logic          cnt_load;
  logic          cnt_run;
  logic          viol_now;
  logic [NP-1:0] lvl_vec, sel_vec, rise_vec, hit_vec;
  logic [SW-1:0] evt_vec;

  assign lvl_vec  = {pin_s, nmi_s};
  assign sel_vec  = {pin_sel, 1'b1};
  assign rise_vec = {pin_rise, nmi_rise};

  assign enter_now = (state == ST_AWAKE) && stby_req;
  assign stby_wait = (state == ST_ASLEEP);

  dsw_edge #(.NP(NP)) u_edge (
    .clk(clk), .rst_n(rst_n), .capture(enter_now),
    .lvl(lvl_vec), .sel(sel_vec), .rise(rise_vec),
    .hit(hit_vec), .viol_now(viol_now)
  );

  // bit 0 NMI, bit 1 alarm, bit 2+i wake pin i
  assign evt_vec  = {hit_vec[NP-1:1], alarm_s, hit_vec[0]};
  assign rst_drop = ((state == ST_ASLEEP) || (state == ST_SETTLE)) && !rst_s;
  assign wake_any = stby_wait && rst_s && (|evt_vec);

  assign cnt_load = stby_wait && (wake_any || !rst_s);
  assign cnt_run  = (state == ST_SETTLE) || (state == ST_PINHOLD);

  dsw_settle_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(settle_cycles),
    .run(cnt_run), .done(cnt_done)
  );

  // state sequencing
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_AWAKE:   if (stby_req) state_nx = ST_ASLEEP;
      ST_ASLEEP: begin
        if (rst_drop)      state_nx = ST_PINHOLD;
        else if (wake_any) state_nx = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (rst_drop)      state_nx = ST_PINHOLD;
        else if (cnt_done) state_nx = ST_PORPULS;
      end
      ST_PORPULS:          state_nx = ST_AWAKE;
      ST_PINHOLD:  if (cnt_done && rst_s) state_nx = ST_AWAKE;
      default:             state_nx = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_AWAKE;
    else        state <= state_nx;
  end

  // status and violation
  logic [SW-1:0] clr_vec, set_vec;
  assign clr_vec = stat_clr_we ? stat_clr_data : '0;
  assign set_vec = wake_any ? evt_vec : '0;

  for (genvar b = 0; b < SW; b++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_status[b] <= 1'b0;
      else        wake_status[b] <= stat_next(wake_status[b], clr_vec[b], set_vec[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     entry_viol <= 1'b0;
    else if (enter_now && viol_now) entry_viol <= 1'b1;
  end

  // outputs
  assign osc_en  = (state != ST_ASLEEP);
  assign clko_en = (state == ST_AWAKE) || (state == ST_PINHOLD);
  assign por_req = (state == ST_PORPULS) || (state == ST_PINHOLD);
  assign in_stby = (state != ST_AWAKE);

endmodule

// File: rtl/dsw_wake_ctrl_chk.sv
module dsw_wake_ctrl_chk #(
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby_req,
  input logic          osc_en,
  input logic          clko_en,
  input logic          por_req,
  input logic          in_stby,
  input logic          entry_viol,
  input logic [SW-1:0] wake_status,
  input logic          stat_clr_we,
  input logic          stby_wait,
  input logic          wake_any,
  input logic          cnt_done,
  input logic          rst_s
);

  p_awake_clocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stby |-> (osc_en && clko_en));

  p_enter_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stby && stby_req) |=> (in_stby && !osc_en && !clko_en));

  p_viol_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_viol |=> entry_viol);

  p_wake_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> (osc_en && !clko_en && !por_req));

  p_por_after_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (por_req && !clko_en) |-> $past(cnt_done));

  p_por_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (por_req && !clko_en) |=> !por_req);

  p_status_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_we |=> ((wake_status & $past(wake_status)) == $past(wake_status)));

  p_pin_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_wait && !rst_s) |=> (por_req && clko_en && osc_en));

  p_hold_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (por_req && clko_en && !cnt_done) |=> por_req);

  p_hold_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (por_req && clko_en && !rst_s) |=> por_req);

endmodule

bind dsw_wake_ctrl dsw_wake_ctrl_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .osc_en(osc_en),
  .clko_en(clko_en), .por_req(por_req), .in_stby(in_stby),
  .entry_viol(entry_viol), .wake_status(wake_status),
  .stat_clr_we(stat_clr_we), .stby_wait(stby_wait), .wake_any(wake_any),
  .cnt_done(cnt_done), .rst_s(rst_s)
);

// File: tb/tb_dsw_wake_ctrl.sv
`timescale 1ns/1ps
module tb_dsw_wake_ctrl;
  localparam int NPINS = 4;
  localparam int CW    = 16;
  localparam int SW    = NPINS + 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stby_req;
  logic             nmi_pin, nmi_rise;
  logic [NPINS-1:0] wake_pin, pin_sel, pin_rise;
  logic             alarm_in, rst_pin_n;
  logic [CW-1:0]    settle_cycles;
  logic             stat_clr_we;
  logic [SW-1:0]    stat_clr_data;
  logic             osc_en, clko_en, por_req, in_stby, entry_viol;
  logic [SW-1:0]    wake_status;

  always #5 clk = ~clk;

  dsw_wake_ctrl #(.NPINS(NPINS), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .nmi_pin(nmi_pin),
    .nmi_rise(nmi_rise), .wake_pin(wake_pin), .pin_sel(pin_sel),
    .pin_rise(pin_rise), .alarm_in(alarm_in), .rst_pin_n(rst_pin_n),
    .settle_cycles(settle_cycles), .stat_clr_we(stat_clr_we),
    .stat_clr_data(stat_clr_data), .osc_en(osc_en), .clko_en(clko_en),
    .por_req(por_req), .in_stby(in_stby), .wake_status(wake_status),
    .entry_viol(entry_viol)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  typedef struct {
    int            len;
    logic [SW-1:0] stat;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_stby();
    @(negedge clk) stby_req = 1'b1;
    @(negedge clk) stby_req = 1'b0;
  endtask

  task automatic push_exp(input int settle, input logic [SW-1:0] st);
    exp_t e;
    e.len  = settle + 1;
    e.stat = st;
    sb_q.push_back(e);
  endtask

  task automatic wait_awake();
    int g = 0;
    while (in_stby && g < 200) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic clear_bits(input logic [SW-1:0] m);
    @(negedge clk);
    stat_clr_we   = 1'b1;
    stat_clr_data = m;
    @(negedge clk);
    stat_clr_we   = 1'b0;
    stat_clr_data = '0;
  endtask

  // monitor: measures oscillator-to-reset distance and compares with scoreboard
  logic prev_osc = 1'b1, prev_por = 1'b0;
  int   run_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_stby && osc_en && !prev_osc && !clko_en) run_len = 1;
      else if (osc_en && !por_req && in_stby && !clko_en) run_len++;
      if (por_req && !prev_por && !clko_en) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: actual unexpected reset pulse expected none");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R5 settle length", run_len, e.len);
          chk("R6 wake status", 32'(wake_status), 32'(e.stat));
        end
      end
      prev_osc = osc_en;
      prev_por = por_req;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [SW-1:0] saved;
    int held;
    rst_n = 1'b0; stby_req = 1'b0; nmi_pin = 1'b1; nmi_rise = 1'b0;
    wake_pin = '0; pin_sel = 4'b0101; pin_rise = 4'b1111;
    alarm_in = 1'b0; rst_pin_n = 1'b1; settle_cycles = 16'd5;
    stat_clr_we = 1'b0; stat_clr_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    chk("R1 in_stby", in_stby, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 clko_en", clko_en, 1);
    chk("R1 por_req", por_req, 0);
    chk("R1 status", wake_status, 0);
    chk("R1 viol", entry_viol, 0);

    // R10 reset pin while awake is ignored
    rst_pin_n = 1'b0;
    cyc(5);
    chk("R10 por_req", por_req, 0);
    chk("R10 in_stby", in_stby, 0);
    rst_pin_n = 1'b1;
    cyc(4);

    // R2 entry, R3 clean entry
    enter_stby();
    chk("R2 in_stby", in_stby, 1);
    chk("R2 osc_en", osc_en, 0);
    chk("R2 clko_en", clko_en, 0);
    chk("R3 clean entry", entry_viol, 0);

    // R4 unselected pin 1 reaching its level
    wake_pin[1] = 1'b1;
    cyc(6);
    chk("R4 unselected osc_en", osc_en, 0);
    chk("R4 unselected in_stby", in_stby, 1);

    // R5/R6/R11 NMI falling edge wake
    push_exp(5, 6'b000001);
    nmi_pin = 1'b0;
    cyc(1);
    chk("R11 sync delay", osc_en, 0);
    wait_awake();
    chk("R5 awake clko", clko_en, 1);
    chk("R5 awake por", por_req, 0);
    nmi_pin = 1'b1; wake_pin[1] = 1'b0;
    cyc(4);

    // R7 clear bit 0
    clear_bits(6'b000001);
    chk("R7 clear", wake_status, 0);

    // R6 simultaneous pin 0 and alarm, zero settle
    settle_cycles = 16'd0;
    enter_stby();
    push_exp(0, 6'b000110);
    wake_pin[0] = 1'b1; alarm_in = 1'b1;
    wait_awake();
    alarm_in = 1'b0;
    cyc(4);

    // R7 clear alarm bit only
    clear_bits(6'b000010);
    chk("R7 partial clear", wake_status, 6'b000100);

    // R3 violation: pin 0 high with rising polarity at entry
    enter_stby();
    chk("R3 viol set", entry_viol, 1);
    chk("R3 still enters", in_stby, 1);
    cyc(6);
    chk("R4 no wake at entry level", osc_en, 0);
    settle_cycles = 16'd3;
    push_exp(3, 6'b000110);
    alarm_in = 1'b1;
    wait_awake();
    alarm_in = 1'b0;
    chk("R3 sticky", entry_viol, 1);
    wake_pin[0] = 1'b0;
    cyc(4);

    // R8/R9 reset pin exit, early release
    settle_cycles = 16'd20;
    enter_stby();
    saved = wake_status;
    rst_pin_n = 1'b0;
    cyc(4);
    chk("R8 osc_en", osc_en, 1);
    chk("R8 clko_en", clko_en, 1);
    chk("R8 por_req", por_req, 1);
    chk("R8 status kept", wake_status, saved);
    rst_pin_n = 1'b1;
    cyc(6);
    chk("R9 held by count", por_req, 1);
    held = 0;
    while (por_req && held < 100) begin
      @(negedge clk);
      held++;
    end
    chk("R9 count wait", (held >= 8) ? 1 : 0, 1);
    chk("R9 awake", in_stby, 0);

    // R9 long pin hold
    settle_cycles = 16'd2;
    cyc(2);
    enter_stby();
    rst_pin_n = 1'b0;
    cyc(10);
    chk("R9 long hold", por_req, 1);
    rst_pin_n = 1'b1;
    cyc(1);
    chk("R9 sync latency", por_req, 1);
    cyc(3);
    chk("R9 release", por_req, 0);
    chk("R9 release awake", in_stby, 0);

    cyc(2);
    chk("R5 scoreboard drained", sb_q.size(), 0);
    done_flag = 1;
    finish_run();
  end
endmodule